// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block couples two 18-bit ports, A and B, with one storage path for each direction of flow. Each path can pass its input straight through to the opposite port, hold a stored word, or load a new word on a rising edge of its own strobe clock. Each path has four controls: a pass select, a strobe clock, an active-low strobe enable and an active-low drive enable. Both paths are built the same way and are fully independent.

The design runs on one system clock. The external strobe clocks are sampled as levels, and a rising strobe edge is found by comparing each sample with the previous one. The transparent mode uses a combinational bypass around a register, so the design contains no latches. The output ports are split into a data vector and a drive-enable bit for each port, so that an outer pad ring can build the tri-state pins.

If both paths are enabled to drive at the same time, both ports are driven. The block does not arbitrate this case, and the user must avoid it.

Top module: `bidir_store_xcvr`

## Requirements
- R1: While a path's pass select is 1, that path's output equals its input in the same cycle, with no register in between.
- R2: While the pass select is 0 and no qualified strobe edge occurs, the output keeps its stored word, whatever the input does.
- R3: With pass select 0 and strobe enable 0, a rising strobe loads the input word into storage. A rising strobe is a strobe sampled 1 on a system clock edge after being sampled 0 on the previous edge. The loaded word appears at the output after that system clock edge.
- R4: While the strobe enable is 1, a rising strobe leaves the stored word unchanged.
- R5: When the pass select goes from 1 to 0, the output holds the input word that was present at the last system clock edge with pass select 1.
- R6: While the pass select is 1, strobe edges have no effect beyond the transparent path: the output stays equal to the input.
- R7: The drive-enable output of a port is 1 exactly when its active-low drive control is 0.
- R8: The B-to-A path behaves as the A-to-B path does, using its own controls. Activity on one path never changes the other path's output.
- R9: Reset clears both stored words to zero. Reset also treats both strobes as previously high, so a strobe that is held high after reset does not count as an edge.
- R10: When both drive controls are 0, both drive-enable outputs are 1 at once. This configuration is legal in the logic but must be avoided by the user.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | Word received on port A |
| b_in | input | 18 | Word received on port B |
| a2b_pass | input | 1 | A-to-B transparent select |
| a2b_strobe | input | 1 | A-to-B load strobe, sampled |
| a2b_strobe_en_n | input | 1 | A-to-B strobe enable, active low |
| a2b_drive_n | input | 1 | B-port drive control, active low |
| b2a_pass | input | 1 | B-to-A transparent select |
| b2a_strobe | input | 1 | B-to-A load strobe, sampled |
| b2a_strobe_en_n | input | 1 | B-to-A strobe enable, active low |
| b2a_drive_n | input | 1 | A-port drive control, active low |
| b_out | output | 18 | Word presented on port B |
| b_drive | output | 1 | Port B drive enable |
| a_out | output | 18 | Word presented on port A |
| a_drive | output | 1 | Port A drive enable |

## Verification
The bench targets the moment the pass select falls. A design that kept the register stale during the transparent phase would present an old word at that point instead of the last passed one. The bench also holds the strobe high across several cycles; a level-sensitive capture would then track the input instead of holding. Strobes are applied with the enable high to catch a missing enable gate, and a strobe left high through reset catches a detector that comes out of reset at 0 and loads a spurious word. Finally, the bench steps one direction while it watches the other, to expose a crossed path.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    localparam int XCVR_DATA_W = 18;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'd0,
        MODE_PASS = 2'd1,
        MODE_LOAD = 2'd2
    } path_mode_e;
endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_in;
        rise      = level_in & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/xcvr_mode_dec.sv
module xcvr_mode_dec
    import xcvr_pkg::*;
(
    input  logic       pass,
    input  logic       rise,
    input  logic       strobe_en_n,
    output path_mode_e mode
);
    always_comb begin
        if (pass) begin
            mode = MODE_PASS;
        end else if (rise && !strobe_en_n) begin
            mode = MODE_LOAD;
        end else begin
            mode = MODE_HOLD;
        end
    end
endmodule

// File: rtl/xcvr_dir_path.sv
module xcvr_dir_path
    import xcvr_pkg::*;
#(
    parameter int WIDTH = XCVR_DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic             pass,
    input  logic             strobe,
    input  logic             strobe_en_n,
    input  logic             drive_n,
    output logic [WIDTH-1:0] dout,
    output logic             drive
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
    } path_st_t;

    path_st_t   st_d, st_q;
    logic       rise;
    path_mode_e mode;

    xcvr_edge_det edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (strobe),
        .rise     (rise)
    );

    xcvr_mode_dec dec_i (
        .pass        (pass),
        .rise        (rise),
        .strobe_en_n (strobe_en_n),
        .mode        (mode)
    );

    always_comb begin
        st_d = st_q;
        unique case (mode)
            MODE_PASS: st_d.word = din;
            MODE_LOAD: st_d.word = din;
            default:   st_d.word = st_q.word;
        endcase
        dout  = (mode == MODE_PASS) ? din : st_q.word;
        drive = ~drive_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/bidir_store_xcvr.sv
module bidir_store_xcvr
    import xcvr_pkg::*;
#(
    parameter int WIDTH = XCVR_DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             a2b_pass,
    input  logic             a2b_strobe,
    input  logic             a2b_strobe_en_n,
    input  logic             a2b_drive_n,
    input  logic             b2a_pass,
    input  logic             b2a_strobe,
    input  logic             b2a_strobe_en_n,
    input  logic             b2a_drive_n,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drive,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drive
);
    localparam int NUM_DIR = 2;

    logic [NUM_DIR-1:0][WIDTH-1:0] din_arr;
    logic [NUM_DIR-1:0][WIDTH-1:0] dout_arr;
    logic [NUM_DIR-1:0]            pass_arr;
    logic [NUM_DIR-1:0]            strobe_arr;
    logic [NUM_DIR-1:0]            en_n_arr;
    logic [NUM_DIR-1:0]            drive_n_arr;
    logic [NUM_DIR-1:0]            drive_arr;

    // index 0: A toward B, index 1: B toward A
    assign din_arr     = {b_in, a_in};
    assign pass_arr    = {b2a_pass, a2b_pass};
    assign strobe_arr  = {b2a_strobe, a2b_strobe};
    assign en_n_arr    = {b2a_strobe_en_n, a2b_strobe_en_n};
    assign drive_n_arr = {b2a_drive_n, a2b_drive_n};

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        xcvr_dir_path #(.WIDTH(WIDTH)) path_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .din         (din_arr[g]),
            .pass        (pass_arr[g]),
            .strobe      (strobe_arr[g]),
            .strobe_en_n (en_n_arr[g]),
            .drive_n     (drive_n_arr[g]),
            .dout        (dout_arr[g]),
            .drive       (drive_arr[g])
        );
    end

    assign b_out   = dout_arr[0];
    assign b_drive = drive_arr[0];
    assign a_out   = dout_arr[1];
    assign a_drive = drive_arr[1];
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int WIDTH = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             a2b_pass,
    input logic             a2b_strobe,
    input logic             a2b_strobe_en_n,
    input logic             b2a_pass,
    input logic             b2a_strobe,
    input logic             b2a_strobe_en_n,
    input logic [WIDTH-1:0] b_out,
    input logic [WIDTH-1:0] a_out
);
    logic armed_q, ab_prev_q, ba_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            ab_prev_q <= 1'b1;
            ba_prev_q <= 1'b1;
        end else begin
            armed_q   <= 1'b1;
            ab_prev_q <= a2b_strobe;
            ba_prev_q <= b2a_strobe;
        end
    end

    logic ab_load, ba_load;
    assign ab_load = !a2b_pass && a2b_strobe && !ab_prev_q && !a2b_strobe_en_n;
    assign ba_load = !b2a_pass && b2a_strobe && !ba_prev_q && !b2a_strobe_en_n;

    assert_ab_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !a2b_pass && !ab_load) ##1 !a2b_pass |-> $stable(b_out));

    assert_ab_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ab_load) ##1 !a2b_pass |-> b_out == $past(a_in));

    assert_ab_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $fell(a2b_pass)) |-> b_out == $past(a_in));

    assert_ba_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !b2a_pass && !ba_load) ##1 !b2a_pass |-> $stable(a_out));

    assert_ba_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ba_load) ##1 !b2a_pass |-> a_out == $past(b_in));

    assert_ba_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $fell(b2a_pass)) |-> a_out == $past(b_in));
endmodule

bind bidir_store_xcvr xcvr_checker #(.WIDTH(WIDTH)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .a_in            (a_in),
    .b_in            (b_in),
    .a2b_pass        (a2b_pass),
    .a2b_strobe      (a2b_strobe),
    .a2b_strobe_en_n (a2b_strobe_en_n),
    .b2a_pass        (b2a_pass),
    .b2a_strobe      (b2a_strobe),
    .b2a_strobe_en_n (b2a_strobe_en_n),
    .b_out           (b_out),
    .a_out           (a_out)
);

// File: tb/bidir_store_xcvr_tb.sv
module bidir_store_xcvr_tb_top;
    localparam int W     = 18;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic a2b_pass = 0, a2b_strobe = 1, a2b_strobe_en_n = 0, a2b_drive_n = 1;
    logic b2a_pass = 0, b2a_strobe = 1, b2a_strobe_en_n = 0, b2a_drive_n = 1;
    logic [W-1:0] b_out, a_out;
    logic         b_drive, a_drive;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    bidir_store_xcvr #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .a2b_pass(a2b_pass), .a2b_strobe(a2b_strobe),
        .a2b_strobe_en_n(a2b_strobe_en_n), .a2b_drive_n(a2b_drive_n),
        .b2a_pass(b2a_pass), .b2a_strobe(b2a_strobe),
        .b2a_strobe_en_n(b2a_strobe_en_n), .b2a_drive_n(b2a_drive_n),
        .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
    );

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // dir 0: A toward B, dir 1: B toward A
    task automatic set_in(int dir, logic [W-1:0] v);
        if (dir == 0) a_in = v; else b_in = v;
    endtask

    task automatic set_ctl(int dir, logic pass, logic strobe, logic en_n);
        if (dir == 0) begin
            a2b_pass = pass; a2b_strobe = strobe; a2b_strobe_en_n = en_n;
        end else begin
            b2a_pass = pass; b2a_strobe = strobe; b2a_strobe_en_n = en_n;
        end
    endtask

    function automatic logic [W-1:0] out_of(int dir);
        return (dir == 0) ? b_out : a_out;
    endfunction

    task automatic run_dir(int dir, logic [W-1:0] p);
        logic [W-1:0] other;
        other = out_of(1 - dir);
        // R1: transparent, same cycle
        set_ctl(dir, 1'b1, 1'b0, 1'b0);
        set_in(dir, p);
        #1 chk("R1 pass-through", out_of(dir), p);
        step();
        // R6: strobe edge while passing only shows the input
        set_in(dir, ~p);
        set_ctl(dir, 1'b1, 1'b1, 1'b0);
        step();
        chk("R6 pass priority", out_of(dir), ~p);
        // R5: pass falls, word of last passing edge held
        set_ctl(dir, 1'b0, 1'b1, 1'b0);
        #1 chk("R5 pass fall", out_of(dir), ~p);
        set_in(dir, p);
        step();
        chk("R2 hold after fall", out_of(dir), ~p);
        // R3: qualified rising strobe loads
        set_ctl(dir, 1'b0, 1'b0, 1'b0);
        step();
        set_in(dir, p);
        set_ctl(dir, 1'b0, 1'b1, 1'b0);
        step();
        chk("R3 load on strobe", out_of(dir), p);
        set_in(dir, ~p);
        step();
        chk("R2 hold with strobe high", out_of(dir), p);
        // R4: enable high blocks load
        set_ctl(dir, 1'b0, 1'b0, 1'b1);
        step();
        set_ctl(dir, 1'b0, 1'b1, 1'b1);
        step();
        chk("R4 strobe gated", out_of(dir), p);
        set_ctl(dir, 1'b0, 1'b1, 1'b0);
        chk("R8 other path untouched", out_of(1 - dir), other);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: cleared storage, held-high strobe is no edge
        chk("R9 reset b_out", b_out, '0);
        chk("R9 reset a_out", a_out, '0);
        a_in = 18'h2AAAA;
        b_in = 18'h15555;
        step();
        step();
        chk("R9 no spurious load b", b_out, '0);
        chk("R9 no spurious load a", a_out, '0);

        // R7: drive controls, active low
        for (int d = 0; d < 2; d++) begin
            a2b_drive_n = d[0];
            b2a_drive_n = ~d[0];
            #1;
            chk("R7 b_drive", {{(W-1){1'b0}}, b_drive}, {{(W-1){1'b0}}, ~d[0]});
            chk("R7 a_drive", {{(W-1){1'b0}}, a_drive}, {{(W-1){1'b0}}, d[0]});
        end
        // R10: both directions enabled, both drive (to be avoided by users)
        a2b_drive_n = 0;
        b2a_drive_n = 0;
        #1 chk("R10 both drive", {{(W-2){1'b0}}, a_drive, b_drive}, {{(W-2){1'b0}}, 2'b11});
        a2b_drive_n = 1;
        b2a_drive_n = 1;
        @(negedge clk);

        // sweep of patterns, both directions
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] p;
            if (i < W) p = W'(1) << i;
            else p = W'((i * 32'h2F3A5 + 17) & ((1 << W) - 1));
            run_dir(0, p);
            run_dir(1, p ^ W'(18'h0F0F0));
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule